// File: doc/BRIEF.md
# Test-Port Key Unlock Gate

This block guards debug access and external boot selection behind a secret key. While the security input is high, both of its permission outputs stay low. The device then runs only from internal memory, and the emulation logic stays closed. A 64-bit key comes in one bit per test clock through a key data register of the test port. That register is loaded while the capture logic holds a shift strobe and selects the key register. On the update strobe, the collected bits are compared with the stored per-device key. An exact match opens both debug and external boot. Anything else is dropped without a trace.

The gate sits next to the test access port controller and runs in the test clock domain. It takes the already decoded shift and update strobes, the register-select qualifier and the serial data bit. The serial key is a plain strobed bit stream with no back-pressure. The block can never refuse a bit, so it has no valid/ready pair. Every other pin is plain control or status.

Top module: `tap_key_gate`

## Requirements
- R1: While `trst_n` is low, and at the first edge after it rises, `debug_enable` and `ext_boot_enable` are 0 and the block holds no unlock.
- R2: When `key_sel` and `shift_dr` are both high at a `tck` rising edge, `tdi` enters at the top of the key register and the register moves one place toward bit 0. The first bit shifted becomes bit 0 after 64 shifts, so a key sent MSB first does not match.
- R3: An update (`update_dr` and `key_sel` high) whose register value equals `dev_key` sets both outputs to 1 at that same edge, provided `sec_en` is high.
- R4: An update with any other value changes nothing visible. It clears the key register to zero, so bits shifted before a failed update never count toward a later key.
- R5: Once unlocked, the block stays unlocked until reset, even after later wrong keys.
- R6: When `sec_en` is low at an edge, both outputs are 1 after that edge. When `sec_en` returns high without an unlock, they fall back to 0 at the next edge.
- R7: Shift and update strobes are ignored while `key_sel` is low. Shifting with `key_sel` low loads nothing, and an update with `key_sel` low neither compares nor clears.
- R8: `debug_enable` and `ext_boot_enable` are registered and always equal.
- R9: The match is a full 64-bit equality, so a key that differs only in bit 63 does not unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| sec_en | input | 1 | Security enforcement; low opens both outputs |
| key_sel | input | 1 | Key data register is the selected register |
| shift_dr | input | 1 | Shift strobe from the port controller |
| update_dr | input | 1 | Update strobe from the port controller |
| tdi | input | 1 | Serial key bit |
| dev_key | input | 64 | Stored per-device key |
| debug_enable | output | 1 | Emulation access permitted |
| ext_boot_enable | output | 1 | External boot modes permitted |

## Verification
The hardest case to reach from the ports is a partial key that survives a failed update. The result of a failed update is silent, so it can only be seen through a later attempt. The bench shifts the low half of the real key and issues an update, which fails and should clear the register. It then shifts only the high half and updates again. If the register had not been cleared, those two halves would form the full key. The bench also sends a correct key with the select held low, and an update with the select low, to show that neither one loads nor clears the register.

// File: rtl/tkg_pkg.sv
package tkg_pkg;
  localparam int KEY_W_DEF = 64;
  typedef enum logic [1:0] {SH_HOLD, SH_SHIFT, SH_CLEAR} sh_op_e;
endpackage

// File: rtl/tkg_shifter.sv
module tkg_shifter #(
  parameter int W = tkg_pkg::KEY_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         shift,
  input  logic         update,
  input  logic         din,
  output logic [W-1:0] key_q
);
  import tkg_pkg::*;
  sh_op_e op;

  always_comb begin
    if (sel && update)     op = SH_CLEAR;
    else if (sel && shift) op = SH_SHIFT;
    else                   op = SH_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else begin
      case (op)
        SH_SHIFT: key_q <= {din, key_q[W-1:1]};
        SH_CLEAR: key_q <= '0;
        default:  key_q <= key_q;
      endcase
    end
  end

  // R4: nothing of a key attempt survives its update
  a_r4_clear_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && update) |=> (key_q == '0));
  // R7: deselected strobes leave the register alone
  a_r7_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(key_q));
endmodule

// File: rtl/tkg_compare.sv
module tkg_compare #(
  parameter int W = tkg_pkg::KEY_W_DEF
) (
  input  logic [W-1:0] got,
  input  logic [W-1:0] ref_key,
  output logic         hit
);
  logic [W-1:0] same;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign same[i] = ~(got[i] ^ ref_key[i]);
  end
  assign hit = &same;
endmodule

// File: rtl/tkg_unlock.sv
module tkg_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_en,
  input  logic commit,
  input  logic hit,
  output logic dbg_q,
  output logic boot_q
);
  logic unlocked_q;
  logic unlocked_d;
  logic open_d;

  assign unlocked_d = unlocked_q | (commit & hit);
  assign open_d     = ~sec_en | unlocked_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      dbg_q      <= 1'b0;
      boot_q     <= 1'b0;
    end else begin
      unlocked_q <= unlocked_d;
      dbg_q      <= open_d;
      boot_q     <= open_d;
    end
  end

  // R5: unlock is sticky
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_q |=> unlocked_q);
  // R4: no unlock without a matching commit
  a_r4_no_unlock_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked_q && !(commit && hit)) |=> !unlocked_q);
  // R3: a matching commit opens debug
  a_r3_match_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && hit) |=> dbg_q);
endmodule

// File: rtl/tap_key_gate.sv
module tap_key_gate #(
  parameter int KEY_W = tkg_pkg::KEY_W_DEF
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             sec_en,
  input  logic             key_sel,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  input  logic [KEY_W-1:0] dev_key,
  output logic             debug_enable,
  output logic             ext_boot_enable
);
  logic [KEY_W-1:0] key_q;
  logic             hit;
  logic             commit;

  assign commit = key_sel & update_dr;

  tkg_shifter #(.W(KEY_W)) u_shift (
    .clk(tck), .rst_n(trst_n), .sel(key_sel), .shift(shift_dr),
    .update(update_dr), .din(tdi), .key_q(key_q)
  );

  tkg_compare #(.W(KEY_W)) u_cmp (
    .got(key_q), .ref_key(dev_key), .hit(hit)
  );

  tkg_unlock u_lock (
    .clk(tck), .rst_n(trst_n), .sec_en(sec_en), .commit(commit), .hit(hit),
    .dbg_q(debug_enable), .boot_q(ext_boot_enable)
  );

  // R8: the two permissions never disagree
  a_r8_outputs_match: assert property (@(posedge tck) disable iff (!trst_n)
    debug_enable == ext_boot_enable);
  // R6: security off opens the gate
  a_r6_open_when_disabled: assert property (@(posedge tck) disable iff (!trst_n)
    !sec_en |=> debug_enable);
endmodule

// File: tb/tap_key_gate_tb.sv
module tap_key_gate_tb;
  localparam int CLK_P = 10;
  localparam logic [63:0] KEY = 64'hA5C3_1E07_9B42_D6F8;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic sec_en = 1'b1;
  logic key_sel = 1'b0;
  logic shift_dr = 1'b0;
  logic update_dr = 1'b0;
  logic tdi = 1'b0;
  logic [63:0] dev_key = KEY;
  logic debug_enable, ext_boot_enable;
  logic sec_v = 1'b1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic  e;
    string t;
  } item_t;
  item_t q[$];
  item_t it;

  always #(CLK_P/2) tck = ~tck;

  tap_key_gate u_dut (
    .tck(tck), .trst_n(trst_n), .sec_en(sec_en), .key_sel(key_sel),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .dev_key(dev_key),
    .debug_enable(debug_enable), .ext_boot_enable(ext_boot_enable)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compare outputs against queued expectations
  always @(negedge tck) begin
    if (q.size() > 0) begin
      it = q.pop_front();
      check(debug_enable, it.e, {it.t, " debug_enable"});
      check(ext_boot_enable, it.e, {it.t, " ext_boot_enable R8"});
    end
  end

  task automatic drive(input logic s, input logic sh, input logic up,
                       input logic b, input logic exp, input string tag);
    item_t x;
    @(negedge tck);
    sec_en = sec_v; key_sel = s; shift_dr = sh; update_dr = up; tdi = b;
    @(posedge tck);
    #1;
    x.e = exp; x.t = tag;
    q.push_back(x);
  endtask

  task automatic send(input logic [63:0] k, input int lo, input int hi,
                      input logic s, input logic exp, input string tag);
    for (int i = lo; i <= hi; i++) drive(s, 1'b1, 1'b0, k[i], exp, tag);
  endtask

  task automatic do_reset();
    @(negedge tck);
    trst_n = 1'b0; key_sel = 0; shift_dr = 0; update_dr = 0; sec_en = 1; sec_v = 1;
    repeat (2) @(negedge tck);
    check(debug_enable, 1'b0, "R1 reset debug");
    check(ext_boot_enable, 1'b0, "R1 reset boot");
    trst_n = 1'b1;
    drive(0, 0, 0, 0, 1'b0, "R1 first edge");
  endtask

  function automatic logic [63:0] rev(input logic [63:0] k);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = k[63-i];
    return r;
  endfunction

  initial begin
    do_reset();
    // R4 wrong key ignored
    send(KEY ^ 64'h1, 0, 63, 1, 0, "R4 wrong shift");
    drive(1, 0, 1, 0, 0, "R4 wrong update");
    drive(0, 0, 0, 0, 0, "R4 after wrong");
    // R4 partial key discarded after failed update
    send(KEY, 0, 31, 1, 0, "R4 low half");
    drive(1, 0, 1, 0, 0, "R4 low half update");
    send(KEY, 32, 63, 1, 0, "R4 high half");
    drive(1, 0, 1, 0, 0, "R4 high half update");
    // R9 only bit 63 differs
    send(KEY ^ 64'h8000_0000_0000_0000, 0, 63, 1, 0, "R9 msb flip");
    drive(1, 0, 1, 0, 0, "R9 msb flip update");
    // R2 order: MSB-first stream does not match
    send(rev(KEY), 0, 63, 1, 0, "R2 reversed order");
    drive(1, 0, 1, 0, 0, "R2 reversed update");
    // R7 shift with key_sel low loads nothing
    send(KEY, 0, 63, 0, 0, "R7 unselected shift");
    drive(1, 0, 1, 0, 0, "R7 update after unselected shift");
    // R7 update with key_sel low neither compares nor clears
    send(KEY, 0, 63, 1, 0, "R2 correct shift");
    drive(0, 0, 1, 0, 0, "R7 unselected update");
    drive(0, 0, 0, 0, 0, "R7 still locked");
    // R3 selected update with intact key unlocks at that edge
    drive(1, 0, 1, 0, 1, "R3 unlock");
    // R5 later wrong key keeps unlock
    send(~KEY, 0, 63, 1, 1, "R5 wrong after unlock");
    drive(1, 0, 1, 0, 1, "R5 wrong update");
    sec_v = 1'b1;
    drive(0, 0, 0, 0, 1, "R5 still open");
    // R1 reset relocks; R6 security disable
    do_reset();
    sec_v = 1'b0;
    drive(0, 0, 0, 0, 1, "R6 sec off");
    drive(0, 0, 0, 0, 1, "R6 sec off hold");
    sec_v = 1'b1;
    drive(0, 0, 0, 0, 0, "R6 sec back on");
    repeat (3) @(negedge tck);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule